// File: doc/BRIEF.md
# Programmable RGB-to-YCbCr Matrix

This block converts one pixel per cycle from RGB to YCbCr on a 10-bit-per-channel display overlay path. A signed pre-offset is added to each input component. The three results are multiplied by a programmable 3x3 signed coefficient matrix, and each product sum is rounded and scaled back to pixel units. A signed post-offset is then added to each output, and the output is saturated to 10 bits. When the enable bit is clear, the pixel passes through unchanged.

Pixels enter and leave on valid/ready streams. The pipeline has a fixed latency of three cycles and stalls as a whole when the consumer holds off. Configuration arrives on a simple word-write port. Each write goes into a shadow copy. The shadow copy becomes the working set only on a frame-start pulse, so no frame ever mixes two coefficient sets. After reset, both copies hold the limited-range video coefficients and offsets, and the enable bit is clear.

Top module: `ycc_matrix_top`

## Requirements
- R1: While reset is low and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: With the enable bit (bit 0 of the word at address 0) clear, `out_y`, `out_cb` and `out_cr` equal `in_r`, `in_g` and `in_b` of the same pixel.
- R3: Pre-offsets are 12-bit two's complement values at addresses 1, 2 and 3, for R, G and B, and are added to the inputs before the multiply.
- R4: Coefficients are 13-bit two's complement values in which 1024 means 1.0. They are packed two per word at addresses 4 to 8, in row-major order c00/c01, c02/c10, c11/c12, c20/c21, c22. The first of each pair sits in bits 28:16 and the second in bits 12:0. Output row 0 is Y, row 1 is Cb and row 2 is Cr. Column 0 multiplies R, column 1 multiplies G and column 2 multiplies B.
- R5: Each product sum has 512 added and is then shifted right arithmetically by 10, so halves round toward plus infinity.
- R6: Post-offsets are 12-bit two's complement values at addresses 9, 10 and 11, for Y, Cb and Cr, and are added after rounding.
- R7: Every converted output is saturated to the range 0 to 1023.
- R8: A pixel accepted at a clock edge appears on the outputs with `out_valid` high after the third edge, counting the accepting edge as the first.
- R9: While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` is low.
- R10: Configuration writes have no effect on the conversion until a `frame_start` pulse. A write in the same cycle as the pulse waits for the next pulse.
- R11: After reset, the coefficients are the limited-range set (Y row 186, 627, 63; Cb row -103, -345, 448; Cr row 448, -407, -41), the post-offsets are 64, 512 and 512, and the pre-offsets are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | One-cycle pulse between frames; loads the shadow configuration |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_r | input | 10 | Red component |
| in_g | input | 10 | Green component |
| in_b | input | 10 | Blue component |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer can take a pixel |
| out_y | output | 10 | Luma, or red in bypass |
| out_cb | output | 10 | Blue-difference chroma, or green in bypass |
| out_cr | output | 10 | Red-difference chroma, or blue in bypass |

## Verification
Each converted or bypassed pixel is due after the third clock edge, counting its accepting edge. The bench checks that `out_valid` is still low after the first and second edges and reads the data after the third, always sampling at the falling edge. A configuration change is due only after the frame-start edge. The bench therefore sends one pixel before the pulse, expects the old result, and expects the new result for a pixel sent after the pulse. During a stall, the outputs and `in_ready` are sampled on several falling edges while `out_ready` is low. `out_valid` is expected to drop one edge after `out_ready` returns.

// File: rtl/ycc_pkg.sv
// Shared widths, register addresses, configuration record and reset
// defaults for the RGB-to-YCbCr matrix. Assumes three channels.
package ycc_pkg;
    localparam int PIX_W     = 10;
    localparam int OFS_W     = 12;
    localparam int COEF_W    = 13;
    localparam int FRAC_W    = 10;
    localparam int NCH       = 3;
    localparam int NCOEF     = NCH * NCH;
    localparam int CFG_AW    = 4;
    localparam int CFG_DW    = 32;
    localparam int HI_LSB    = 16;
    localparam int PRE_SUM_W = OFS_W + 2;
    localparam int SUM_W     = PRE_SUM_W + COEF_W + 2;
    localparam int ROUND     = 1 << (FRAC_W - 1);
    localparam int PIX_MAX   = (1 << PIX_W) - 1;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_PRE0  = 1;
    localparam int ADDR_COEF0 = ADDR_PRE0 + NCH;
    localparam int ADDR_POST0 = ADDR_COEF0 + (NCOEF + 1) / 2;

    typedef struct packed {
        logic                            en;
        logic [NCH-1:0][OFS_W-1:0]       pre;
        logic [NCOEF-1:0][COEF_W-1:0]    coef;
        logic [NCH-1:0][OFS_W-1:0]       post;
    } cfg_t;

    // Limited-range video conversion, enable clear.
    function automatic cfg_t cfg_default();
        cfg_t c;
        c.en      = 1'b0;
        c.pre     = '0;
        c.coef[0] = COEF_W'(186);
        c.coef[1] = COEF_W'(627);
        c.coef[2] = COEF_W'(63);
        c.coef[3] = COEF_W'(-103);
        c.coef[4] = COEF_W'(-345);
        c.coef[5] = COEF_W'(448);
        c.coef[6] = COEF_W'(448);
        c.coef[7] = COEF_W'(-407);
        c.coef[8] = COEF_W'(-41);
        c.post[0] = OFS_W'(64);
        c.post[1] = OFS_W'(512);
        c.post[2] = OFS_W'(512);
        return c;
    endfunction
endpackage

// File: rtl/ycc_cfg_regs.sv
// Configuration store. Writes land in a shadow copy, and the working copy
// loads from the shadow only on frame_start. Assumes frame_start arrives
// while no pixel is in flight.
module ycc_cfg_regs
    import ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              frame_start,
    output cfg_t              act_cfg
);
    cfg_t shadow_q, shadow_d;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^{cfg_wdata[CFG_DW-1:HI_LSB+COEF_W],
                                 cfg_wdata[HI_LSB-1:COEF_W]};

    // Decode a write into the next shadow value.
    always_comb begin
        shadow_d = shadow_q;
        if (cfg_we) begin
            if (cfg_addr == CFG_AW'(ADDR_CTRL))
                shadow_d.en = cfg_wdata[0];
            for (int i = 0; i < NCH; i++) begin
                if (cfg_addr == CFG_AW'(ADDR_PRE0 + i))
                    shadow_d.pre[i] = cfg_wdata[OFS_W-1:0];
                if (cfg_addr == CFG_AW'(ADDR_POST0 + i))
                    shadow_d.post[i] = cfg_wdata[OFS_W-1:0];
            end
            for (int c = 0; c < NCOEF; c++) begin
                if (cfg_addr == CFG_AW'(ADDR_COEF0 + c / 2))
                    shadow_d.coef[c] = (c % 2 == 0) ? cfg_wdata[HI_LSB +: COEF_W]
                                                    : cfg_wdata[0 +: COEF_W];
            end
        end
    end

    // Hold the shadow and copy it to the working set at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= cfg_default();
            act_cfg  <= cfg_default();
        end else begin
            shadow_q <= shadow_d;
            if (frame_start)
                act_cfg <= shadow_q;
        end
    end
endmodule

// File: rtl/ycc_pipe.sv
// Three-stage conversion pipeline: pre-offset, then matrix multiply-accumulate,
// then round, post-offset, saturate and bypass select. The whole pipe
// advances when its last stage is empty or is being drained.
module ycc_pipe
    import ycc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  cfg_t                      cfg,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [NCH-1:0][PIX_W-1:0] in_pix,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [NCH-1:0][PIX_W-1:0] out_pix
);
    logic adv;
    logic v1, v2, v3, en1, en2;
    logic [NCH-1:0][PIX_W-1:0] raw1, raw2;
    logic signed [PRE_SUM_W-1:0] pre1 [NCH];
    logic signed [SUM_W-1:0]     sum2 [NCH];
    logic signed [SUM_W-1:0]     sum_c [NCH];
    logic [NCH-1:0][PIX_W-1:0]   conv_c;

    assign adv      = !v3 || out_ready;
    assign in_ready = adv;
    assign out_valid = v3;

    // Valid bits move one stage per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
        end else if (adv) begin
            v1 <= in_valid; v2 <= v1; v3 <= v2;
        end
    end

    // Stage 1: add pre-offsets; keep the raw pixel and the enable.
    always_ff @(posedge clk) begin
        if (adv) begin
            en1  <= cfg.en;
            raw1 <= in_pix;
            for (int i = 0; i < NCH; i++)
                pre1[i] <= PRE_SUM_W'($signed({1'b0, in_pix[i]}))
                         + PRE_SUM_W'($signed(cfg.pre[i]));
        end
    end

    // Row-by-column multiply-accumulate on the offset pixel.
    always_comb begin
        for (int r = 0; r < NCH; r++) begin
            sum_c[r] = '0;
            for (int k = 0; k < NCH; k++)
                sum_c[r] = sum_c[r] + SUM_W'(pre1[k])
                         * SUM_W'($signed(cfg.coef[r*NCH+k]));
        end
    end

    // Stage 2: register the sums.
    always_ff @(posedge clk) begin
        if (adv) begin
            en2  <= en1;
            raw2 <= raw1;
            for (int i = 0; i < NCH; i++) sum2[i] <= sum_c[i];
        end
    end

    // Per channel: round, scale, post-offset, clamp.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic signed [SUM_W-1:0] scaled, total;
        always_comb begin
            scaled = (sum2[g] + SUM_W'(ROUND)) >>> FRAC_W;
            total  = scaled + SUM_W'($signed(cfg.post[g]));
            if (total < 0)
                conv_c[g] = '0;
            else if (total > SUM_W'(PIX_MAX))
                conv_c[g] = PIX_W'(PIX_MAX);
            else
                conv_c[g] = total[PIX_W-1:0];
        end
    end

    // Stage 3: choose converted or pass-through pixel.
    always_ff @(posedge clk) begin
        if (adv) out_pix <= en2 ? conv_c : raw2;
    end
endmodule

// File: rtl/ycc_matrix_top.sv
// Top of the RGB-to-YCbCr matrix: configuration store plus conversion
// pipeline. Assumes frame_start pulses only between frames.
module ycc_matrix_top
    import ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_y,
    output logic [PIX_W-1:0]  out_cb,
    output logic [PIX_W-1:0]  out_cr
);
    cfg_t act_cfg;
    logic [NCH-1:0][PIX_W-1:0] pix_i, pix_o;

    assign pix_i  = {in_b, in_g, in_r};
    assign out_y  = pix_o[0];
    assign out_cb = pix_o[1];
    assign out_cr = pix_o[2];

    ycc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .act_cfg(act_cfg)
    );

    ycc_pipe u_pipe (
        .clk(clk), .rst_n(rst_n), .cfg(act_cfg), .in_valid(in_valid),
        .in_ready(in_ready), .in_pix(pix_i), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(pix_o)
    );
endmodule

// File: rtl/ycc_matrix_chk.sv
// Protocol and configuration checks for ycc_matrix_top, bound to it.
module ycc_matrix_chk
    import ycc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_cb,
    input logic [PIX_W-1:0] out_cr,
    input cfg_t             act_cfg
);
    // R1: nothing valid on the first cycle out of reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && in_ready));

    // R9: a stalled output holds its data
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_y, out_cb, out_cr})));

    // R9: no intake while the output is stalled
    a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10: the working configuration changes only after a frame start
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_cfg));
endmodule

bind ycc_matrix_top ycc_matrix_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y),
    .out_cb(out_cb), .out_cr(out_cr), .act_cfg(act_cfg)
);

// File: tb/sim_ycc_matrix_top.sv
module sim_ycc_matrix_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [9:0]  in_r = '0, in_g = '0, in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [9:0]  out_y, out_cb, out_cr;

    int total = 0, bad = 0;
    bit done = 0;

    // Bench mirror of the configuration: pending (written) and active.
    int p_en, p_pre[3], p_coef[9], p_post[3];
    int a_en, a_pre[3], a_coef[9], a_post[3];

    always #10 clk = ~clk;

    ycc_matrix_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y),
        .out_cb(out_cb), .out_cr(out_cr)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result from the requirements, using the active mirror.
    task automatic model(input int r, input int g, input int b,
                         output int y, output int cb, output int cr);
        int x[3], o[3], s;
        x[0] = r + a_pre[0]; x[1] = g + a_pre[1]; x[2] = b + a_pre[2];
        for (int i = 0; i < 3; i++) begin
            s = x[0]*a_coef[i*3] + x[1]*a_coef[i*3+1] + x[2]*a_coef[i*3+2];
            s = ((s + 512) >>> 10) + a_post[i];
            o[i] = (s < 0) ? 0 : (s > 1023) ? 1023 : s;
        end
        if (a_en == 0) begin o[0] = r; o[1] = g; o[2] = b; end
        y = o[0]; cb = o[1]; cr = o[2];
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 32'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(input int en, input int pre[3], input int coef[9],
                           input int post[3]);
        wr(0, en);
        for (int i = 0; i < 3; i++) wr(1 + i, pre[i] & 'hfff);
        for (int k = 0; k < 5; k++)
            wr(4 + k, ((coef[2*k] & 'h1fff) << 16) | ((k < 4) ? (coef[2*k+1] & 'h1fff) : 0));
        for (int i = 0; i < 3; i++) wr(9 + i, post[i] & 'hfff);
        p_en = en; p_pre = pre; p_coef = coef; p_post = post;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        a_en = p_en; a_pre = p_pre; a_coef = p_coef; a_post = p_post;
    endtask

    // One pixel through the pipe with latency checks (R8).
    task automatic push(input string req, input int r, input int g, input int b);
        int ey, ecb, ecr;
        model(r, g, b, ey, ecb, ecr);
        @(negedge clk);
        in_valid = 1'b1; in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 edge1 valid", int'(out_valid), 0);
        @(negedge clk);
        chk("R8 edge2 valid", int'(out_valid), 0);
        @(negedge clk);
        chk("R8 edge3 valid", int'(out_valid), 1);
        chk({req, " y"},  int'(out_y),  ey);
        chk({req, " cb"}, int'(out_cb), ecb);
        chk({req, " cr"}, int'(out_cr), ecr);
    endtask

    task automatic t_reset();
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 in_ready in reset", int'(in_ready), 1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_bypass();
        push("R2 bypass", 100, 200, 300);
        push("R2 bypass extremes", 1023, 0, 511);
    endtask

    task automatic t_defaults();
        wr(0, 1); p_en = 1;
        pulse_frame();
        push("R11 default white", 1023, 1023, 1023);
        push("R11 default black", 0, 0, 0);
        push("R11 default red", 1023, 0, 0);
    endtask

    task automatic t_pre();
        int pre[3] = '{-100, 50, 0};
        int co[9]  = '{1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
        int po[3]  = '{0, 0, 0};
        set_cfg(1, pre, co, po); pulse_frame();
        push("R3 pre-offset", 300, 300, 300);
    endtask

    task automatic t_pack();
        int pre[3] = '{0, 0, 0};
        int co[9]  = '{0, 1024, 0, 0, 0, 1024, 1024, 0, 0};
        int po[3]  = '{0, 0, 0};
        set_cfg(1, pre, co, po); pulse_frame();
        push("R4 packing permute", 11, 222, 733);
    endtask

    task automatic t_round();
        int pre[3] = '{0, 0, 0};
        int co[9]  = '{512, 0, 0, 0, -512, 0, 0, 0, 512};
        int po[3]  = '{0, 10, 0};
        set_cfg(1, pre, co, po); pulse_frame();
        push("R5 rounding", 5, 3, 1);
    endtask

    task automatic t_post_sat();
        int pre[3] = '{0, 0, 0};
        int co[9]  = '{1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
        int po[3]  = '{64, -20, 2047};
        int co2[9] = '{-1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
        int po2[3] = '{0, 0, 0};
        set_cfg(1, pre, co, po); pulse_frame();
        push("R6 R7 post-offset and high clamp", 10, 30, 0);
        set_cfg(1, pre, co2, po2); pulse_frame();
        push("R7 R4 negative coefficient low clamp", 500, 7, 8);
    endtask

    task automatic t_frame();
        int pre[3] = '{0, 0, 0};
        int co[9]  = '{0, 0, 1024, 1024, 0, 0, 0, 1024, 0};
        int po[3]  = '{1, 2, 3};
        set_cfg(1, pre, co, po);
        push("R10 old config before pulse", 40, 50, 60);
        chk("R10 old y literal", int'(out_y), 0);
        pulse_frame();
        push("R10 new config after pulse", 40, 50, 60);
        chk("R10 new y literal", int'(out_y), 61);
        wr(0, 0); p_en = 0;
        push("R10 disable pending", 40, 50, 60);
        pulse_frame();
        push("R10 R2 disable applied", 40, 50, 60);
    endtask

    task automatic t_stall();
        int ey, ecb, ecr;
        model(123, 456, 789, ey, ecb, ecr);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_r = 10'd123; in_g = 10'd456; in_b = 10'd789;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 valid at stall", int'(out_valid), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 valid held", int'(out_valid), 1);
            chk("R9 in_ready low", int'(in_ready), 0);
            chk("R9 y held", int'(out_y), ey);
            chk("R9 cr held", int'(out_cr), ecr);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R9 drained", int'(out_valid), 0);
        chk("R9 in_ready back", int'(in_ready), 1);
    endtask

    initial begin
        a_en = 0; a_pre = '{0, 0, 0}; a_post = '{64, 512, 512};
        a_coef = '{186, 627, 63, -103, -345, 448, 448, -407, -41};
        p_en = a_en; p_pre = a_pre; p_coef = a_coef; p_post = a_post;
        @(negedge clk); @(negedge clk);
        t_reset();
        t_bypass();
        t_defaults();
        t_pre();
        t_pack();
        t_round();
        t_post_sat();
        t_frame();
        t_stall();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule